// File: doc/BRIEF.md
# Switch Current-Limit Chopper with Startup Mask

This block sits between the bridge control logic and the gate drivers of a full H-bridge. Each of the bridge switches has its own current-limit chopper. When the switch's low-threshold current comparator reports an excess, that switch alone is forced off for a fixed number of clock cycles. It is then handed back to its gate request with no outside action. If the comparator is still high when the switch comes back, the switch chops again.

A separate high-threshold comparator per switch feeds a hard-overcurrent path. A rising edge on any of these comparators produces a single-cycle protection pulse for the downstream shutdown latch.

When the bridge enable rises, a startup mask turns current limiting off so that inrush current can flow. The mask ends when an external delay-threshold flag is seen. It runs once per enable assertion, and the enable must fall and rise again to get it back. The hard-overcurrent path stays armed the whole time.

All asynchronous inputs pass through a two-flop synchronizer: the enable, the delay flag and both comparator sets. The gate request and the latch state are treated as synchronous.

Top module: `cl_chopper`

## Requirements
- R1: With the synchronized enable high, no off-time running and `latch_off` low, `sw_en[i]` follows `gate_req[i]` combinationally, and each switch is independent of the others. A change on `bridge_on` reaches `sw_en` two clock edges after it is applied.
- R2: A limit comparator that rises while its switch is requested and not masked forces that switch off from the third clock edge after the rise. The switch stays off for exactly `OFF_CYCLES` cycles and then re-enables by itself.
- R3: If the limit comparator stays high, the switch gets exactly one on-cycle after each off-time and is then forced off again for another `OFF_CYCLES` cycles.
- R4: From the rise of the synchronized enable, limit trips are ignored until the synchronized delay flag is high. The first trip can load the off-timer on the fourth clock edge after the flag is applied.
- R5: The startup mask is not re-armed while the enable stays high. Once it has ended, a later fall of the delay flag leaves limiting active.
- R6: A rising edge on any hard-overcurrent comparator gives `ocp_pulse` high for one cycle on the third clock edge after the rise, whether or not limiting is masked and whether or not an off-time is running. A rise while the enable is low gives no pulse.
- R7: `latch_off` high drives every `sw_en` bit low at once.
- R8: With the synchronized enable low, every `sw_en` bit is low and every running off-time is cancelled, so a new enable sees all switches available.
- R9: During reset `sw_en` and `ocp_pulse` are low, whatever the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bridge_on | input | 1 | Bridge enable, asynchronous |
| mask_end | input | 1 | Delay-threshold flag that ends the startup mask, asynchronous |
| latch_off | input | 1 | Global shutdown from the protection latch |
| gate_req | input | NUM_SW | Per-switch on request |
| lim_cmp | input | NUM_SW | Per-switch current-limit comparator, asynchronous |
| ovc_cmp | input | NUM_SW | Per-switch hard-overcurrent comparator, asynchronous |
| sw_en | output | NUM_SW | Gated per-switch enable |
| ocp_pulse | output | 1 | One-cycle hard-overcurrent pulse |

## Verification
Several properties are checked on every cycle:
- an off-timer reloads to its full length on a trip and counts down one per cycle;
- the timers clear while the enable is low;
- no trip happens while the mask is active;
- the mask arms on an enable rise and cannot return while the enable stays high;
- a hard-overcurrent rise during the mask still yields a pulse.

Only the bench scenarios can show the behaviour seen at the ports. That covers the exact cycle counts from a comparator edge to `sw_en` and `ocp_pulse`, the one-cycle gap during persistent chopping, the independence of the switches, and the one-shot mask seen across enable cycles.

// File: rtl/cl_chop_pkg.sv
package cl_chop_pkg;

  // Next value of an off-time counter: clear wins, then load, then count down.
  function automatic logic [31:0] off_count_next(input logic [31:0] cur,
                                                 input logic        load,
                                                 input logic        clear,
                                                 input logic [31:0] reload);
    if (clear)          return 32'd0;
    else if (load)      return reload;
    else if (cur != 0)  return cur - 32'd1;
    else                return 32'd0;
  endfunction

  // Next state of the startup mask flag.
  function automatic logic mask_next(input logic cur,
                                     input logic en,
                                     input logic en_rise,
                                     input logic release_flag);
    if (!en)               return 1'b0;
    else if (en_rise)      return 1'b1;
    else if (release_flag) return 1'b0;
    else                   return cur;
  endfunction

endpackage

// File: rtl/cl_sync_bank.sv
module cl_sync_bank #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int CHAIN_W = W * STAGES;

  logic [CHAIN_W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[CHAIN_W-W-1:0], d};
  end

  assign q = chain_q[CHAIN_W-1 -: W];
endmodule

// File: rtl/cl_startup_mask.sv
module cl_startup_mask (
  input  logic clk,
  input  logic rst_n,
  input  logic en_s,
  input  logic flag_s,
  output logic mask_o,
  output logic en_rise_o
);
  import cl_chop_pkg::*;

  logic en_d_q;
  logic mask_q;

  assign en_rise_o = en_s & ~en_d_q;
  assign mask_o    = mask_q | en_rise_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_d_q <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      en_d_q <= en_s;
      mask_q <= mask_next(mask_q, en_s, en_rise_o, flag_s);
    end
  end

  // R4: an enable rise always arms the mask
  assert_mask_arm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise_o |=> mask_q);

  // R5: once ended, the mask stays off while the enable stays high
  assert_mask_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask_q && en_d_q && en_s) |=> !mask_q);
endmodule

// File: rtl/cl_off_timer.sv
module cl_off_timer #(
  parameter int OFF_CYCLES = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_s,
  input  logic limit_ok,
  input  logic lim_s,
  input  logic req,
  output logic off_active,
  output logic trip_o
);
  import cl_chop_pkg::*;

  localparam int CW = $clog2(OFF_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  assign off_active = (cnt_q != '0);
  assign trip_o     = en_s & limit_ok & lim_s & req & ~off_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= CW'(off_count_next(32'(cnt_q), trip_o, ~en_s, 32'(OFF_CYCLES)));
  end

  // R2: a trip loads the full off-time
  assert_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    trip_o |=> (cnt_q == CW'(OFF_CYCLES)));

  // R2: the off-time counts down one per cycle while enabled
  assert_countdown_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (off_active && en_s) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R8: enable low cancels the off-time
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |=> !off_active);
endmodule

// File: rtl/cl_ocp_edge.sv
module cl_ocp_edge #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_s,
  input  logic [W-1:0] ovc_s,
  output logic         rise_any_o,
  output logic         pulse_o
);
  logic [W-1:0] ovc_d_q;
  logic         pulse_q;

  assign rise_any_o = |(ovc_s & ~ovc_d_q);
  assign pulse_o    = pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovc_d_q <= '0;
      pulse_q <= 1'b0;
    end else begin
      ovc_d_q <= ovc_s;
      pulse_q <= en_s & rise_any_o;
    end
  end

  // R6: a pulse only follows a cycle with the enable high
  assert_pulse_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_q) |-> $past(en_s));
endmodule

// File: rtl/cl_chopper.sv
module cl_chopper #(
  parameter int NUM_SW      = 4,
  parameter int OFF_CYCLES  = 300,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bridge_on,
  input  logic              mask_end,
  input  logic              latch_off,
  input  logic [NUM_SW-1:0] gate_req,
  input  logic [NUM_SW-1:0] lim_cmp,
  input  logic [NUM_SW-1:0] ovc_cmp,
  output logic [NUM_SW-1:0] sw_en,
  output logic              ocp_pulse
);
  localparam int SYNC_W = 2 + 2 * NUM_SW;

  logic [SYNC_W-1:0] sync_q;
  logic              en_s;
  logic              flag_s;
  logic [NUM_SW-1:0] lim_s;
  logic [NUM_SW-1:0] ovc_s;
  logic              mask_w;
  logic              en_rise_w;
  logic              ocp_rise_w;
  logic [NUM_SW-1:0] off_w;
  logic [NUM_SW-1:0] trip_w;

  cl_sync_bank #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({bridge_on, mask_end, lim_cmp, ovc_cmp}),
    .q    (sync_q)
  );

  assign {en_s, flag_s, lim_s, ovc_s} = sync_q;

  cl_startup_mask u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_s     (en_s),
    .flag_s   (flag_s),
    .mask_o   (mask_w),
    .en_rise_o(en_rise_w)
  );

  for (genvar i = 0; i < NUM_SW; i++) begin : g_sw
    cl_off_timer #(.OFF_CYCLES(OFF_CYCLES)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_s      (en_s),
      .limit_ok  (~mask_w),
      .lim_s     (lim_s[i]),
      .req       (gate_req[i]),
      .off_active(off_w[i]),
      .trip_o    (trip_w[i])
    );
    assign sw_en[i] = gate_req[i] & en_s & ~off_w[i] & ~latch_off;
  end

  cl_ocp_edge #(.W(NUM_SW)) u_ocp (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_s      (en_s),
    .ovc_s     (ovc_s),
    .rise_any_o(ocp_rise_w),
    .pulse_o   (ocp_pulse)
  );

  // R4: no limit trip while the startup mask is active
  assert_mask_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mask_w |-> (trip_w == '0));

  // R6: hard overcurrent stays armed during the mask
  assert_ocp_in_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_w && en_s && ocp_rise_w) |=> ocp_pulse);

  // R4: the mask never outlives a seen enable rise without arming
  assert_rise_masks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise_w |-> mask_w);
endmodule

// File: tb/tb_cl_chopper.sv
module tb_cl_chopper;
  localparam int NSW = 4;
  localparam int OFF = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bridge_on = 1'b0;
  logic mask_end = 1'b0;
  logic latch_off = 1'b0;
  logic [NSW-1:0] gate_req = '0;
  logic [NSW-1:0] lim_cmp = '0;
  logic [NSW-1:0] ovc_cmp = '0;
  wire  [NSW-1:0] sw_en;
  wire            ocp_pulse;

  cl_chopper #(.NUM_SW(NSW), .OFF_CYCLES(OFF), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .bridge_on(bridge_on), .mask_end(mask_end),
    .latch_off(latch_off), .gate_req(gate_req), .lim_cmp(lim_cmp),
    .ovc_cmp(ovc_cmp), .sw_en(sw_en), .ocp_pulse(ocp_pulse)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int         at;
    string      rq;
    logic [4:0] sel;
    logic [4:0] val;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // Driver side: queue an expectation on {ocp_pulse, sw_en} for a cycle.
  task automatic expect_at(input int at, input string rq,
                           input logic [4:0] sel, input logic [4:0] val);
    exp_t e;
    e.at = at; e.rq = rq; e.sel = sel; e.val = val;
    sb.push_back(e);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  // Monitor: compares at the falling edge, before the driver's #1 updates.
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].at == cyc) begin
        logic [4:0] obs;
        obs = {ocp_pulse, sw_en};
        checks++;
        if ((obs & sb[i].sel) != (sb[i].val & sb[i].sel)) begin
          fails++;
          $display("FAIL %s cycle %0d: actual %05b expected %05b (mask %05b)",
                   sb[i].rq, cyc, obs & sb[i].sel, sb[i].val & sb[i].sel, sb[i].sel);
        end
        sb.delete(i);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int c, c2, c3;
    // R9: reset state with requests and comparators active
    tick(1);
    gate_req = 4'hF; lim_cmp = 4'hF; ovc_cmp = 4'hF; bridge_on = 1'b1;
    expect_at(cyc + 2, "R9", 5'h1F, 5'h00);
    tick(4);
    gate_req = '0; lim_cmp = '0; ovc_cmp = '0; bridge_on = 1'b0;
    tick(1);
    rst_n = 1'b1;
    tick(3);

    // R8: enable low keeps all switches off
    gate_req = 4'hF; c = cyc;
    expect_at(c + 1, "R8", 5'h1F, 5'h00);
    tick(3);

    // R1: enable passes requests after two edges
    bridge_on = 1'b1; mask_end = 1'b1; gate_req = 4'b0101; c = cyc;
    expect_at(c + 1, "R1", 5'h0F, 5'h00);
    expect_at(c + 2, "R1", 5'h0F, 5'h05);
    tick(10);
    gate_req = 4'b1110; c = cyc;
    expect_at(c + 1, "R1", 5'h0F, 5'h0E);
    tick(4);

    // R2: single limit event on switch 0
    gate_req = 4'hF; lim_cmp = 4'b0001; c = cyc;
    expect_at(c + 2, "R2", 5'h0F, 5'h0F);
    expect_at(c + 3, "R2", 5'h0F, 5'h0E);
    expect_at(c + 2 + OFF, "R2", 5'h0F, 5'h0E);
    expect_at(c + 3 + OFF, "R2", 5'h0F, 5'h0F);
    tick(1);
    lim_cmp = '0;
    tick(OFF + 8);

    // R3: persistent limit on switch 2 chops with one on-cycle gaps
    lim_cmp = 4'b0100; c = cyc;
    expect_at(c + 3, "R3", 5'h0F, 5'h0B);
    expect_at(c + 3 + OFF, "R3", 5'h0F, 5'h0F);
    expect_at(c + 4 + OFF, "R3", 5'h0F, 5'h0B);
    expect_at(c + 4 + 2 * OFF, "R3", 5'h0F, 5'h0F);
    expect_at(c + 5 + 2 * OFF, "R3", 5'h0F, 5'h0B);
    tick(2 * OFF + 6);
    lim_cmp = '0;
    tick(OFF + 6);

    // R6: hard overcurrent pulse
    ovc_cmp = 4'b0010; c = cyc;
    expect_at(c + 2, "R6", 5'h10, 5'h00);
    expect_at(c + 3, "R6", 5'h10, 5'h10);
    expect_at(c + 4, "R6", 5'h10, 5'h00);
    tick(6);
    ovc_cmp = '0;
    tick(4);

    // R6: pulse also during a running off-time
    lim_cmp = 4'b0001; c = cyc;
    tick(5);
    ovc_cmp = 4'b0001; c2 = cyc;
    expect_at(c2 + 3, "R6", 5'h1F, 5'h1E);
    tick(6);
    lim_cmp = '0; ovc_cmp = '0;
    tick(OFF + 6);

    // R8: enable low cancels a running off-time; R6: no pulse while disabled
    lim_cmp = 4'b0001;
    tick(5);
    bridge_on = 1'b0; lim_cmp = '0; ovc_cmp = 4'b0100; c2 = cyc;
    expect_at(c2 + 2, "R8", 5'h0F, 5'h00);
    expect_at(c2 + 3, "R6", 5'h10, 5'h00);
    expect_at(c2 + 4, "R6", 5'h10, 5'h00);
    tick(4);
    bridge_on = 1'b1; c3 = cyc;
    expect_at(c3 + 2, "R8", 5'h0F, 5'h0F);
    expect_at(c3 + 3, "R6", 5'h10, 5'h00);
    tick(3);
    ovc_cmp = '0;
    tick(OFF);

    // R4: startup mask holds off limiting until the delay flag
    bridge_on = 1'b0; mask_end = 1'b0;
    tick(4);
    bridge_on = 1'b1; lim_cmp = 4'b0001; c = cyc;
    expect_at(c + 2, "R4", 5'h0F, 5'h0F);
    expect_at(c + 3, "R4", 5'h0F, 5'h0F);
    expect_at(c + 5 + OFF, "R4", 5'h0F, 5'h0F);
    tick(OFF + 6);
    ovc_cmp = 4'b1000; c2 = cyc;
    expect_at(c2 + 3, "R6", 5'h1F, 5'h1F);
    tick(6);
    ovc_cmp = '0;
    tick(2);
    mask_end = 1'b1; c3 = cyc;
    expect_at(c3 + 3, "R4", 5'h0F, 5'h0F);
    expect_at(c3 + 4, "R4", 5'h0F, 5'h0E);
    tick(6);
    lim_cmp = '0;
    tick(OFF + 4);

    // R5: flag falling later does not bring the mask back
    mask_end = 1'b0;
    tick(4);
    lim_cmp = 4'b0010; c = cyc;
    expect_at(c + 3, "R5", 5'h0F, 5'h0D);
    tick(4);
    lim_cmp = '0;
    tick(OFF + 4);

    // R7: latch forces all off immediately
    latch_off = 1'b1; c = cyc;
    expect_at(c + 1, "R7", 5'h0F, 5'h00);
    tick(3);
    latch_off = 1'b0; c = cyc;
    expect_at(c + 1, "R7", 5'h0F, 5'h0F);
    tick(5);

    if (sb.size() != 0) begin
      fails += sb.size();
      $display("FAIL scoreboard: actual %0d unchecked, expected 0", sb.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule